// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an 8-line general-purpose I/O port sitting behind a simple memory-mapped register bus with byte-wide data and zero wait states. Every line has its own direction bit. When a line is an output, the block drives its pad enable and the value held in a per-line output latch. When it is an input, its pad level is brought into the clock domain through a two-flop synchronizer before software can see it.

The data register is not a single address. It is a window in which address bits [9:2] act as a per-line mask. A read returns the levels of only the masked lines, and a write touches only the latch bits that are masked and also configured as outputs. Software can therefore set, clear or sample one line at offset `1 << (n+2)` without a read-modify-write sequence. The port also holds an interrupt-enable byte that a separate interrupt-detection block uses. Pad cells, edge and level detection, and the bus bridge lie outside this block.

Top module: `gpio_mask_port`

## Requirements
- R1: The port has 8 lines. Any offset below 0x400 is a data access whose line mask is address bits [9:2], so line n is reached alone at offset 1<<(n+2) and all lines together at 0x3FC.
- R2: The direction byte sits at offset 0x400 and reads back as written. Bit n = 1 makes line n an output, and `pad_oe[n]` follows that bit starting from the cycle after the write.
- R3: A data read returns zero in every bit position whose mask bit is 0.
- R4: A data write changes output latch bit n only when mask bit n = 1 and direction bit n = 1. `pad_out` always shows the latch.
- R5: For an input line, a masked data read returns the pad level through a two-flop synchronizer. A change on `pad_in` becomes visible to a read whose access phase comes after the second rising clock edge following the change, and not earlier.
- R6: For an output line, a masked data read returns the latch value, whatever the pad input is.
- R7: Reset makes every line an input and clears both the output latch and the interrupt-enable byte. The interrupt-enable byte is read and written at offset 0x410 and drives `irq_en`.
- R8: A read of any offset at or above 0x400 other than exactly 0x400 or 0x410 (for example 0x404 or 0x401) returns zero. A write there changes no state. A write takes effect at the clock edge of its access phase (`psel` and `penable` both 1), and read data is valid during that phase.
- R9: A value written to a line while it is an input is lost. When the line is later switched to an output, it drives the value its latch held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the access |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid in a read access phase, 0 otherwise |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Output latch driven to the pads |
| pad_oe | output | 8 | Pad output enables (direction byte) |
| irq_en | output | 8 | Interrupt-enable byte for the detection block |

## Verification
Data writes are issued with the full mask (0x3FC), with single-line masks, and against lines that are inputs. Together these show whether the gate is the mask, the direction, or both, and whether a discarded write leaves any trace once the line becomes an output. Reads are made with partial masks while `pad_in` and the latch disagree, so that a swapped source or a leaking unmasked bit is visible. The synchronizer is probed with a pad change placed one and two edges ahead of a read, which separates two stages from one or three. A long random mix of mapped, unmapped and misaligned accesses with random pad levels is then compared against a behavioural model on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register offsets that software relies on
  localparam logic [15:0] DIR_OFS = 16'h0400;
  localparam logic [15:0] IEN_OFS = 16'h0410;

  // Decoded target of a bus access
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DATA = 2'd1,
    RGN_DIR  = 2'd2,
    RGN_IEN  = 2'd3
  } region_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  // Cycles since reset, saturating, for the latency check only
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R5: output is the input seen exactly two edges earlier
  a_r5_two_stage_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  region_e          region,
  input  logic [NPINS-1:0] amask,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] ien_q
);

  logic             dir_en;
  logic             ien_en;
  logic             dat_en;
  logic [NPINS-1:0] dir_d;
  logic [NPINS-1:0] ien_d;
  logic [NPINS-1:0] out_d;

  // Next-state logic
  always_comb begin
    dir_en = wr && (region == RGN_DIR);
    ien_en = wr && (region == RGN_IEN);
    dat_en = wr && (region == RGN_DATA);
    dir_d  = dir_en ? wdata : dir_q;
    ien_d  = ien_en ? wdata : ien_q;
  end

  // Per-line latch enable: masked and configured as output
  for (genvar gi = 0; gi < NPINS; gi++) begin : g_latch
    logic bit_en;
    assign bit_en     = dat_en && amask[gi] && dir_q[gi];
    assign out_d[gi]  = bit_en ? wdata[gi] : out_q[gi];

    // R4: an input line's latch bit never moves
    a_r4_input_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_q[gi] |=> $stable(out_q[gi]));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ien_q <= '0;
      out_q <= '0;
    end else begin
      dir_q <= dir_d;
      ien_q <= ien_d;
      out_q <= out_d;
    end
  end

  // R8: a write outside the mapped registers changes nothing
  a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (region == RGN_NONE)) |=> ($stable(dir_q) && $stable(ien_q) && $stable(out_q)));

  // R7: first edge after reset release sees cleared state
  a_r7_reset_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((dir_q == '0) && (ien_q == '0) && (out_q == '0)));

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  region_e          region,
  input  logic [NPINS-1:0] amask,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] ien_q,
  input  logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] rdata
);

  logic [NPINS-1:0] level;

  // Per-line source: latch for outputs, synchronized pad for inputs
  for (genvar gi = 0; gi < NPINS; gi++) begin : g_level
    assign level[gi] = dir_q[gi] ? out_q[gi] : pin_sync[gi];
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (region)
        RGN_DATA: rdata = level & amask;
        RGN_DIR:  rdata = dir_q;
        RGN_IEN:  rdata = ien_q;
        default:  rdata = '0;
      endcase
    end
  end

  // R8: unmapped reads return zero
  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (region == RGN_NONE)) |-> (rdata == '0));

  // R3: no bit outside the mask appears on a data read
  a_r3_mask_gates_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (region == RGN_DATA)) |-> ((rdata & ~amask) == '0));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [NPINS-1:0]  pwdata,
  output logic [NPINS-1:0]  prdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  irq_en
);

  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + NPINS - 1;

  logic             acc;
  logic             wr;
  logic             rd;
  region_e          region;
  logic [NPINS-1:0] amask;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] ien_q;

  // Access decode (zero wait states)
  always_comb begin
    acc   = psel && penable;
    wr    = acc && pwrite;
    rd    = acc && !pwrite;
    amask = paddr[MASK_HI:MASK_LO];
    if (paddr[ADDR_W-1:MASK_HI+1] == '0)        region = RGN_DATA;
    else if (paddr == DIR_OFS[ADDR_W-1:0])      region = RGN_DIR;
    else if (paddr == IEN_OFS[ADDR_W-1:0])      region = RGN_IEN;
    else                                        region = RGN_NONE;
  end

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr),
    .region (region),
    .amask  (amask),
    .wdata  (pwdata),
    .dir_q  (dir_q),
    .out_q  (out_q),
    .ien_q  (ien_q)
  );

  gpio_rdmux #(.NPINS(NPINS)) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (rd),
    .region   (region),
    .amask    (amask),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .ien_q    (ien_q),
    .pin_sync (pin_sync),
    .rdata    (prdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq_en  = ien_q;

  // R2: a direction write shows on the pad enables one cycle later
  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (region == RGN_DIR)) |=> (pad_oe == $past(pwdata)));

  // R7: an enable write reaches irq_en one cycle later
  a_r7_ien_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (region == RGN_IEN)) |=> (irq_en == $past(pwdata)));

endmodule

// File: tb/gpio_mask_port_bench.sv
`timescale 1ns/1ps
module gpio_mask_port_bench;

  logic        clk;
  logic        rst_n;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [11:0] paddr;
  logic [7:0]  pwdata;
  logic [7:0]  prdata;
  logic [7:0]  pad_in;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;
  logic [7:0]  irq_en;

  int checks;
  int failures;
  int cycles;
  bit done;

  gpio_mask_port u_gpio_mask_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .irq_en  (irq_en)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference model
  logic [7:0] m_dir, m_out, m_ien, m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 8'h00; m_out = 8'h00; m_ien = 8'h00; m_s1 = 8'h00; m_s2 = 8'h00;
    end else begin
      if (psel && penable && pwrite) begin
        if (paddr < 12'h400) begin
          for (int i = 0; i < 8; i++)
            if (paddr[i+2] && m_dir[i]) m_out[i] = pwdata[i];
        end else if (paddr == 12'h400) m_dir = pwdata;
        else if (paddr == 12'h410) m_ien = pwdata;
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  function automatic logic [7:0] model_read(input logic [11:0] a);
    logic [7:0] r;
    r = 8'h00;
    if (a < 12'h400) begin
      for (int i = 0; i < 8; i++)
        if (a[i+2]) r[i] = m_dir[i] ? m_out[i] : m_s2[i];
    end else if (a == 12'h400) r = m_dir;
    else if (a == 12'h410) r = m_ien;
    return r;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      check(pad_oe,  m_dir, "R2 pad_oe vs model");
      check(pad_out, m_out, "R4 pad_out vs model");
      check(irq_en,  m_ien, "R7 irq_en vs model");
      if (psel && penable && !pwrite)
        check(prdata, model_read(paddr), "R3 prdata vs model");
      else
        check(prdata, 8'h00, "R8 prdata idle zero");
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    logic [7:0] rv;
    checks = 0; failures = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pad_in = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    @(negedge clk); #1;
    check(pad_oe, 8'h00, "R7 reset dir");
    check(pad_out, 8'h00, "R7 reset latch");
    check(irq_en, 8'h00, "R7 reset irq_en");
    bus_read(12'h400, rv); check(rv, 8'h00, "R7 reset dir readback");

    // R2 direction
    bus_write(12'h400, 8'h0F);
    #1 check(pad_oe, 8'h0F, "R2 pad_oe after dir write");
    bus_read(12'h400, rv); check(rv, 8'h0F, "R2 dir readback");

    // R4 full-mask write only reaches outputs
    bus_write(12'h3FC, 8'hA5);
    #1 check(pad_out, 8'h05, "R4 full mask write gated by dir");

    // R1 single-line addressing
    bus_write(12'h008, 8'hFF);
    #1 check(pad_out, 8'h07, "R1 set line 1 at 0x008");
    bus_write(12'h010, 8'h00);
    #1 check(pad_out, 8'h03, "R1 clear line 2 at 0x010");

    // R4/R9 writes to an input line are lost
    bus_write(12'h080, 8'hFF);
    #1 check(pad_out, 8'h03, "R4 write to input line 5 ignored");
    bus_write(12'h400, 8'hFF);
    #1 check(pad_out, 8'h03, "R9 line 5 keeps old latch when made output");
    bus_write(12'h080, 8'h20);
    #1 check(pad_out, 8'h23, "R9 line 5 takes write once output");

    // R3/R6 reads with pads disagreeing with latch
    bus_write(12'h400, 8'h0F);
    pad_in = 8'h5C;
    repeat (3) @(negedge clk);
    bus_read(12'h3FC, rv); check(rv, 8'h53, "R6 outputs read latch, inputs read pad");
    bus_read(12'h0C0, rv); check(rv, 8'h10, "R3 partial mask 0x30");
    bus_read(12'h00C, rv); check(rv, 8'h03, "R6 output lines 0-1 ignore pad");
    bus_read(12'h000, rv); check(rv, 8'h00, "R3 empty mask reads zero");

    // R5 synchronizer: one edge is not enough
    @(negedge clk);
    pad_in = 8'hDC;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h200;
    @(negedge clk);
    penable = 1'b1;
    #1 check(prdata, 8'h00, "R5 change not visible after one edge");
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    // two edges are enough
    @(negedge clk);
    pad_in = 8'h5C;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h200;
    @(negedge clk);
    penable = 1'b1;
    #1 check(prdata, 8'h00, "R5 fall visible after two edges");
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;

    // R8 unmapped offsets
    bus_write(12'h404, 8'hFF);
    bus_write(12'h401, 8'hFF);
    bus_write(12'h7FC, 8'hFF);
    bus_write(12'hC00, 8'hFF);
    #1 check(pad_oe, 8'h0F, "R8 unmapped writes leave dir");
    check(pad_out, 8'h23, "R8 unmapped writes leave latch");
    check(irq_en, 8'h00, "R8 unmapped writes leave irq_en");
    bus_read(12'h404, rv); check(rv, 8'h00, "R8 read 0x404 zero");
    bus_read(12'h401, rv); check(rv, 8'h00, "R8 read 0x401 zero");

    // R7 interrupt enable byte
    bus_write(12'h410, 8'h3C);
    #1 check(irq_en, 8'h3C, "R7 irq_en after write");
    bus_read(12'h410, rv); check(rv, 8'h3C, "R7 irq_en readback");

    // Random mix compared with the model on every clock
    for (int k = 0; k < 600; k++) begin
      logic [11:0] a;
      logic [7:0]  d;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0, 1:    a = {2'b00, 8'($urandom), 2'b00};
        2:       a = 12'h400;
        3:       a = 12'h410;
        default: a = 12'($urandom);
      endcase
      d = 8'($urandom);
      pad_in = 8'($urandom);
      if ($urandom_range(0, 1) == 0) bus_write(a, d);
      else bus_read(a, rv);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule